// File: doc/BRIEF.md
# Serial-In Latched Output Driver Logic

This block is the digital core of a serial-to-parallel output driver that can be chained with others. Everything runs on one system clock. A serial clock, serial data and a strobe arrive from outside, and all three pass through two-flop synchronizers. Each rising edge of the synchronized serial clock shifts the synchronized data bit into the first stage of an N-stage register. Bits already in the register move one stage toward the far end. The last stage drives a serial output, which can feed the serial data input of the next device in a chain.

A hold bank sits behind the register. While the strobe is high, the bank keeps copying the register. While the strobe is low, the bank keeps its contents. Each channel's "sink on" output follows its hold bit, except that an active-low output enable, when driven high, forces every channel off. Blanking the outputs this way leaves both the register and the hold bank untouched. If the strobe is tied high, the hold bank is transparent and the shifting pattern reaches the outputs directly. In that mode the enable is kept high during serial entry so the loads do not see the pattern as it moves.

Top module: `serial_sink_driver`

## Requirements
- R1: Data enters stage 1 (`sink_on_o[0]` after transfer) only on a rising edge of the serial clock. On that edge, stage k+1 takes the old value of stage k. With no edge, the register does not change, even if the serial data input toggles.
- R2: `ser_out_o` always equals the last stage (stage N). After N edges, it carries the first bit that was shifted in.
- R3: While the strobe is high, the hold bank copies the register.
- R4: While the strobe is low, the hold bank keeps its value while the register shifts.
- R5: While `out_en_n_i` is 1, every bit of `sink_on_o` is 0. When the enable returns to 0, the earlier hold contents and register contents reappear unchanged.
- R6: While `out_en_n_i` is 0, `sink_on_o[k]` equals hold bit k, and bit k holds stage k+1. A 1 means the channel sinks current.
- R7: With the strobe held high, each shifted pattern appears on `sink_on_o` without any strobe pulse, unless the enable is high.
- R8: Reset (`rst_n` low) clears the register and the hold bank, so `sink_on_o` is 0 and `ser_out_o` is 0.
- R9: A serial clock that stays high for many system cycles shifts the register exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data in (asynchronous) |
| strobe_i | input | 1 | Hold bank transparent while high (asynchronous) |
| out_en_n_i | input | 1 | Active-low output enable; 1 forces all channels off |
| ser_out_o | output | 1 | Last register stage, for cascading |
| sink_on_o | output | N | Per-channel sink-on drive |

## Verification
A rising edge on the serial clock or strobe pins takes effect on the third system clock edge after the drive. Two of those edges are synchronizer stages and one is the register or hold update. `ser_out_o` changes in that same cycle. The enable acts on `sink_on_o` combinationally, with no delay. The bench drives all inputs on falling clock edges and waits four full cycles before it samples on a falling edge. Every result is therefore settled when it is read, and no check depends on the exact cycle in which a result lands.

// File: rtl/sink_drv_pkg.sv
package sink_drv_pkg;
  parameter int unsigned DEF_CHANNELS = 8;

  typedef struct packed {
    logic sclk;
    logic sdat;
    logic stb;
  } pin_bundle_t;

  localparam int unsigned PIN_W = $bits(pin_bundle_t);
endpackage

// File: rtl/sink_sync.sv
module sink_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/sink_shift.sv
module sink_shift #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic [N-1:0] stage_o
);
  logic         sclk_prev_q;
  logic         shift_en;
  logic [N-1:0] stage_q;
  logic [N-1:0] stage_d;

  assign shift_en = sclk_s & ~sclk_prev_q;

  generate
    if (N == 1) begin : g_single
      always_comb begin
        stage_d = stage_q;
        if (shift_en) stage_d = sdat_s;
      end
    end else begin : g_multi
      always_comb begin
        stage_d = stage_q;
        if (shift_en) stage_d = {stage_q[N-2:0], sdat_s};
      end

      // R2: the far stage takes the old value of its neighbour on a shift
      p_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stage_q[N-1] == $past(stage_q[N-2]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      stage_q     <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      stage_q     <= stage_d;
    end
  end

  assign stage_o = stage_q;

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_q[0] == $past(sdat_s));

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stage_q));

  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);
endmodule

// File: rtl/sink_hold.sv
module sink_hold #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_s,
  input  logic [N-1:0] stage_i,
  input  logic         en_n_i,
  output logic [N-1:0] sink_o
);
  logic [N-1:0] hold_q;
  logic [N-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (stb_s) hold_d = stage_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  for (genvar ch = 0; ch < N; ch++) begin : g_chan
    assign sink_o[ch] = hold_q[ch] & ~en_n_i;
  end

  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb_s |=> hold_q == $past(stage_i));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_s |=> $stable(hold_q));

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |-> $countones(sink_o) == 0);
endmodule

// File: rtl/serial_sink_driver.sv
module serial_sink_driver
  import sink_drv_pkg::*;
#(
  parameter int unsigned N = DEF_CHANNELS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk_i,
  input  logic         ser_data_i,
  input  logic         strobe_i,
  input  logic         out_en_n_i,
  output logic         ser_out_o,
  output logic [N-1:0] sink_on_o
);
  pin_bundle_t  pins_raw;
  pin_bundle_t  pins_s;
  logic [N-1:0] stage;

  assign pins_raw = '{sclk: ser_clk_i, sdat: ser_data_i, stb: strobe_i};

  sink_sync #(.W(PIN_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pins_raw),
    .sync_o (pins_s)
  );

  sink_shift #(.N(N)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_s (pins_s.sclk),
    .sdat_s (pins_s.sdat),
    .stage_o(stage)
  );

  sink_hold #(.N(N)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_s  (pins_s.stb),
    .stage_i(stage),
    .en_n_i (out_en_n_i),
    .sink_o (sink_on_o)
  );

  assign ser_out_o = stage[N-1];
endmodule

// File: tb/serial_sink_driver_test.sv
module serial_sink_driver_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk_i = 1'b0;
  logic         ser_data_i = 1'b0;
  logic         strobe_i = 1'b0;
  logic         out_en_n_i = 1'b0;
  logic         ser_out_o;
  logic [N-1:0] sink_on_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_sink_driver #(.N(N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk_i (ser_clk_i),
    .ser_data_i(ser_data_i),
    .strobe_i  (strobe_i),
    .out_en_n_i(out_en_n_i),
    .ser_out_o (ser_out_o),
    .sink_on_o (sink_on_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic d, input int high_cycles);
    ser_data_i = d;
    step(4);
    ser_clk_i = 1'b1;
    step(high_cycles);
    ser_clk_i = 1'b0;
    step(4);
  endtask

  task automatic load(input logic [N-1:0] pat);
    for (int i = N - 1; i >= 0; i--) shift_bit(pat[i], 4);
  endtask

  task automatic strobe_pulse();
    strobe_i = 1'b1;
    step(4);
    strobe_i = 1'b0;
    step(4);
  endtask

  task automatic t_reset();
    chk("R8 sink after reset", 32'(sink_on_o), 32'h0);
    chk("R8 ser_out after reset", 32'(ser_out_o), 32'h0);
  endtask

  task automatic t_load_show();
    load(8'hA5);
    chk("R4 hold keeps reset value", 32'(sink_on_o), 32'h0);
    chk("R2 ser_out is last stage", 32'(ser_out_o), 32'h1);
    strobe_pulse();
    chk("R3 R6 strobe transfers pattern", 32'(sink_on_o), 32'hA5);
  endtask

  task automatic t_hold();
    load(8'h3C);
    chk("R4 hold while shifting", 32'(sink_on_o), 32'hA5);
    chk("R2 ser_out follows new pattern", 32'(ser_out_o), 32'h0);
    strobe_pulse();
    chk("R3 second transfer", 32'(sink_on_o), 32'h3C);
  endtask

  task automatic t_blank();
    out_en_n_i = 1'b1;
    step(1);
    chk("R5 enable high blanks", 32'(sink_on_o), 32'h0);
    shift_bit(1'b1, 4);
    chk("R1 R2 one shift moves bit6 out", 32'(ser_out_o), 32'h0);
    chk("R5 still blank after shift", 32'(sink_on_o), 32'h0);
    out_en_n_i = 1'b0;
    step(1);
    chk("R5 hold contents kept", 32'(sink_on_o), 32'h3C);
    strobe_pulse();
    chk("R1 shift direction", 32'(sink_on_o), 32'h79);
  endtask

  task automatic t_long_pulse();
    shift_bit(1'b0, 20);
    strobe_pulse();
    chk("R9 long clock high shifts once", 32'(sink_on_o), 32'hF2);
  endtask

  task automatic t_no_edge();
    ser_data_i = 1'b1; step(4);
    ser_data_i = 1'b0; step(4);
    ser_data_i = 1'b1; step(4);
    strobe_pulse();
    chk("R1 data toggles without clock ignored", 32'(sink_on_o), 32'hF2);
  endtask

  task automatic t_transparent();
    strobe_i = 1'b1;
    out_en_n_i = 1'b1;
    load(8'h81);
    chk("R7 R5 blank during entry", 32'(sink_on_o), 32'h0);
    out_en_n_i = 1'b0;
    step(1);
    chk("R7 pattern without strobe pulse", 32'(sink_on_o), 32'h81);
    shift_bit(1'b0, 4);
    chk("R7 shift flows to outputs", 32'(sink_on_o), 32'h02);
    strobe_i = 1'b0;
    step(4);
  endtask

  task automatic t_mid_reset();
    rst_n = 1'b0;
    step(2);
    chk("R8 reset clears hold", 32'(sink_on_o), 32'h0);
    chk("R8 reset clears register", 32'(ser_out_o), 32'h0);
    rst_n = 1'b1;
    step(4);
    strobe_pulse();
    chk("R8 register empty after reset", 32'(sink_on_o), 32'h0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_load_show();
    t_hold();
    t_blank();
    t_long_pulse();
    t_no_edge();
    t_transparent();
    t_mid_reset();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end
endmodule